// File: doc/BRIEF.md
# Branch Direction Predictor with Static Fallback

This block sits beside the fetch stage and guesses, in the same cycle as the fetch, whether a branch will be taken. Fetch supplies the program counter of the instruction, a flag saying the instruction is a branch, and the sign of that branch's displacement. The block answers with a single predicted-taken bit. The answer comes from a small table of per-branch history, indexed by low program-counter bits. A fixed rule covers any branch whose table entry has not yet been trained.

The fixed rule treats a branch that jumps backwards as the closing edge of a loop, so it predicts taken. It treats a forward branch as a skipped conditional body, so it predicts not taken. When a branch resolves later in the pipeline, the resolution port reports the branch's program counter and its real outcome, and the entry is trained from that. The first resolution of a branch sets its entry valid with a weak counter that leans toward the observed outcome. Each later resolution moves a two-bit saturating counter one step toward that outcome. A resolution flagged as mispredicted also raises a registered redirect indication one cycle later, so the pipeline can stall and refetch the correct path.

Top module: `brp_predictor`

## Requirements
- R1: While `rst_n` is low every table entry is marked invalid, so after reset every branch is predicted by the static rule until its entry is trained.
- R2: A branch (`fetch_is_br`=1) whose entry is invalid and whose displacement is negative (`fetch_disp_neg`=1) is predicted taken (`pred_taken`=1).
- R3: A branch whose entry is invalid and whose displacement is zero or positive (`fetch_disp_neg`=0) is predicted not taken.
- R4: When `fetch_is_br` is 0, `pred_taken` is 0.
- R5: The first resolution that writes an invalid entry marks it valid and loads counter value 2 (weakly taken) if `res_taken`=1, or value 1 (weakly not taken) if `res_taken`=0. A single later resolution in the opposite direction flips the prediction.
- R6: A later resolution with `res_taken`=1 increments a valid counter, which saturates at 3.
- R7: A later resolution with `res_taken`=0 decrements a valid counter, which saturates at 0.
- R8: The entry is selected by PC bits [7:2] (64 entries). Program counters that differ only in other bits share an entry; ones that differ in bits [7:2] do not.
- R9: If a lookup and a resolution hit the same entry in the same cycle, the lookup sees the value from before the update. The new value is visible from the next cycle on.
- R10: `redirect` is 1 in the cycle after a cycle with `res_valid`=1 and `res_mispred`=1, and is 0 after every other cycle.
- R11: For a valid entry, `pred_taken` equals the counter's upper bit (taken when the counter is 2 or 3), whatever the displacement sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Program counter of the instruction being fetched |
| fetch_is_br | input | 1 | Fetched instruction is a conditional branch |
| fetch_disp_neg | input | 1 | Branch displacement is negative (backward branch) |
| pred_taken | output | 1 | Predicted direction for the fetched branch |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 32 | Program counter of the resolving branch |
| res_taken | input | 1 | Actual outcome of the resolving branch |
| res_mispred | input | 1 | The resolving branch was predicted wrongly |
| redirect | output | 1 | Registered mispredict indication for stall and refetch |

## Verification
The bench builds the block with its default parameters: a 32-bit program counter, six index bits starting at bit 2, and two-bit counters. With these values, entries can be aliased on purpose by program counters 4 KiB apart, and both saturation limits can be reached with a handful of resolutions. Saturation is observed through the prediction: a counter pushed past its limit must need exactly two opposite resolutions to flip, where a wrapping counter would flip early. The same-entry read/write collision and the return to static prediction after a second reset are both reachable with these values.

// File: rtl/brp_pkg.sv
package brp_pkg;

    localparam int CTR_W = 2;

    typedef struct packed {
        logic             vld;
        logic [CTR_W-1:0] ctr;
    } hist_t;

    // Next entry value from the current entry and the resolved outcome
    function automatic hist_t hist_step(hist_t cur, logic taken);
        hist_t nxt;
        nxt.vld = 1'b1;
        if (!cur.vld) begin
            nxt.ctr = taken ? {1'b1, {(CTR_W-1){1'b0}}} : {1'b0, {(CTR_W-1){1'b1}}};
        end else if (taken) begin
            nxt.ctr = (&cur.ctr) ? cur.ctr : cur.ctr + 1'b1;
        end else begin
            nxt.ctr = (cur.ctr == '0) ? cur.ctr : cur.ctr - 1'b1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/brp_static.sv
module brp_static (
    input  logic disp_neg,
    output logic guess_taken
);
    // Backward branches close loops, forward ones skip bodies
    always_comb begin
        guess_taken = disp_neg;
    end
endmodule

// File: rtl/brp_table.sv
module brp_table
    import brp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output hist_t            rd_entry,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_en,
    input  logic             wr_taken,
    output hist_t            wr_old
);
    localparam int ENTRIES = 1 << IDX_W;

    hist_t mem_q [ENTRIES];
    hist_t mem_d [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_idx] = hist_step(mem_q[wr_idx], wr_taken);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    // Reads see registered contents: a same-cycle write is not yet visible
    assign rd_entry = mem_q[rd_idx];
    assign wr_old   = mem_q[wr_idx];
endmodule

// File: rtl/brp_predictor.sv
module brp_predictor
    import brp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            fetch_is_br,
    input  logic            fetch_disp_neg,
    output logic            pred_taken,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic            res_mispred,
    output logic            redirect
);
    typedef struct packed {
        logic redirect;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0] look_idx;
    logic [IDX_W-1:0] upd_idx;
    hist_t            look_entry;
    hist_t            upd_old;
    logic             static_taken;

    assign look_idx = IDX_W'(fetch_pc >> IDX_LSB);
    assign upd_idx  = IDX_W'(res_pc >> IDX_LSB);

    brp_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (look_idx),
        .rd_entry (look_entry),
        .wr_idx   (upd_idx),
        .wr_en    (res_valid),
        .wr_taken (res_taken),
        .wr_old   (upd_old)
    );

    brp_static u_static (
        .disp_neg    (fetch_disp_neg),
        .guess_taken (static_taken)
    );

    always_comb begin
        if (!fetch_is_br) begin
            pred_taken = 1'b0;
        end else if (look_entry.vld) begin
            pred_taken = look_entry.ctr[CTR_W-1];
        end else begin
            pred_taken = static_taken;
        end
    end

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.redirect = res_valid & res_mispred;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign redirect = ctl_q.redirect;

    logic unused_old;
    assign unused_old = ^upd_old;
endmodule

// File: rtl/brp_checker.sv
module brp_checker #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] fetch_pc,
    input logic            fetch_is_br,
    input logic            fetch_disp_neg,
    input logic            pred_taken,
    input logic            res_valid,
    input logic            res_mispred,
    input logic            redirect
);
    logic trained_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trained_q <= 1'b0;
        end else if (res_valid) begin
            trained_q <= 1'b1;
        end
    end

    AST_NONBR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_is_br |-> !pred_taken); // R4

    AST_STATIC_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (!trained_q && fetch_is_br) |-> (pred_taken == fetch_disp_neg)); // R1

    AST_REDIRECT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_mispred) |=> redirect); // R10

    AST_REDIRECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && res_mispred) |=> !redirect); // R10

    logic unused_pc;
    assign unused_pc = ^fetch_pc;
endmodule

bind brp_predictor brp_checker #(.PC_W(PC_W)) u_brp_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_pc       (fetch_pc),
    .fetch_is_br    (fetch_is_br),
    .fetch_disp_neg (fetch_disp_neg),
    .pred_taken     (pred_taken),
    .res_valid      (res_valid),
    .res_mispred    (res_mispred),
    .redirect       (redirect)
);

// File: tb/test_brp_predictor.sv
module test_brp_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        fetch_is_br = 1'b0;
    logic        fetch_disp_neg = 1'b0;
    logic        pred_taken;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic        res_mispred = 1'b0;
    logic        redirect;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    brp_predictor i_brp_predictor (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_is_br(fetch_is_br),
        .fetch_disp_neg(fetch_disp_neg), .pred_taken(pred_taken), .res_valid(res_valid),
        .res_pc(res_pc), .res_taken(res_taken), .res_mispred(res_mispred), .redirect(redirect)
    );

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic look(logic [31:0] pc, logic br, logic neg, string req, logic exp);
        fetch_pc = pc; fetch_is_br = br; fetch_disp_neg = neg;
        #1;
        check(req, pred_taken, exp);
    endtask

    task automatic resolve(logic [31:0] pc, logic tk, logic mis);
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc; res_taken = tk; res_mispred = mis;
        @(negedge clk);
        res_valid = 1'b0; res_mispred = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_static();
        look(32'h0000_0004, 1, 1, "R2 backward untrained", 1);
        look(32'h0000_0004, 1, 0, "R3 forward untrained", 0);
        look(32'h0000_0004, 0, 1, "R4 not a branch", 0);
        check("R10 redirect after reset", redirect, 0);
    endtask

    task automatic t_first_train();
        resolve(32'h10, 0, 1);
        look(32'h10, 1, 1, "R5 first NT overrides backward rule", 0);
        look(32'h10, 1, 1, "R11 valid entry ignores sign", 0);
        resolve(32'h20, 1, 1);
        look(32'h20, 1, 0, "R5 first T overrides forward rule", 1);
        resolve(32'h10, 1, 0);
        look(32'h10, 1, 0, "R5 weak NT flips after one T", 1);
        resolve(32'h20, 0, 0);
        look(32'h20, 1, 1, "R5 weak T flips after one NT", 0);
    endtask

    task automatic t_sat_up();
        for (int i = 0; i < 5; i++) resolve(32'h30, 1, 0);
        resolve(32'h30, 0, 0);
        look(32'h30, 1, 0, "R6 saturated at 3, one NT keeps taken", 1);
        resolve(32'h30, 0, 0);
        look(32'h30, 1, 0, "R6 second NT flips", 0);
    endtask

    task automatic t_sat_down();
        for (int i = 0; i < 5; i++) resolve(32'h40, 0, 0);
        resolve(32'h40, 1, 0);
        look(32'h40, 1, 1, "R7 saturated at 0, one T keeps NT", 0);
        resolve(32'h40, 1, 0);
        look(32'h40, 1, 1, "R7 second T flips", 1);
    endtask

    task automatic t_alias();
        resolve(32'h50, 1, 0);
        look(32'h1050, 1, 0, "R8 alias shares entry", 1);
        look(32'h54, 1, 0, "R8 neighbour index untouched", 0);
        look(32'h51, 1, 0, "R8 low bits ignored", 1);
    endtask

    task automatic t_collide();
        @(negedge clk);
        res_valid = 1'b1; res_pc = 32'h60; res_taken = 1'b1; res_mispred = 1'b0;
        look(32'h60, 1, 0, "R9 same-cycle lookup sees old", 0);
        @(negedge clk);
        res_valid = 1'b0;
        look(32'h60, 1, 0, "R9 new value next cycle", 1);
    endtask

    task automatic t_redirect();
        resolve(32'h70, 1, 1);
        check("R10 redirect after mispredict", redirect, 1);
        @(negedge clk);
        check("R10 redirect drops", redirect, 0);
        resolve(32'h70, 1, 0);
        check("R10 no redirect on correct prediction", redirect, 0);
    endtask

    task automatic t_reset_again();
        do_reset();
        look(32'h20, 1, 1, "R1 trained entry cleared by reset", 1);
        look(32'h30, 1, 1, "R1 cleared entry uses backward rule", 1);
        look(32'h40, 1, 0, "R1 cleared entry uses forward rule", 0);
    endtask

    initial begin
        do_reset();
        t_reset_static();
        t_first_train();
        t_sat_up();
        t_sat_down();
        t_alias();
        t_collide();
        t_redirect();
        t_reset_again();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule